// File: doc/BRIEF.md
# Cyclic Channel and Gain Scan Sequencer

This block keeps a short programmable list of scan entries. Each entry names an analog input channel and a four-bit gain code, which carries both the amplifier gain and the reference/offset choice. Once acquisition is started, every advance strobe from the conversion timing logic presents the next entry on the multiplexer select and amplifier control lines. Consecutive samples can therefore come from different channels at different ranges. After the last entry the list starts again at the first, and this repeats until acquisition is stopped.

A host port writes entries one at a time and sets the list length. Writes that carry an unsupported gain code are refused and raise a sticky error flag. A clear strobe drops that flag and, during a run, sends the pointer back to the first entry. In differential mode only eight channels exist, so the top select line is forced low.

The control is a three-state machine. S_IDLE means no acquisition is running. S_STEP means running with the pointer short of the final entry. S_LAST means running with the pointer on the final entry. The transitions are: start (S_IDLE to S_STEP, or to S_LAST when the length is one); advance (S_STEP to S_STEP or S_LAST, and S_LAST back to S_STEP or S_LAST with the pointer at zero); restart by start or clear (running to its first state); and stop (any state to S_IDLE).

Top module: `scan_sequencer`

## Requirements
- R1: After reset the outputs read `mux_sel`=0, gain code 0, `active`=0, `cur_idx`=0 and `wr_err`=0, and every list entry holds channel 0 with gain code 0.
- R2: While running, a cycle with `adv` high loads the entry at `cur_idx` onto the output lines at the next clock edge, and `cur_idx` moves to the following entry.
- R3: After the entry at index length−1 is presented, `cur_idx` returns to 0. The sequence then repeats for as long as the run lasts.
- R4: The output lines change only on an accepted advance. An `adv` seen while in S_IDLE changes neither the outputs nor `cur_idx`.
- R5: In single-ended mode (`diff_mode`=0), `mux_sel` equals the full 4-bit channel field. In differential mode, `mux_sel[3]` is 0 and `mux_sel[2:0]` equals the low three bits of the channel field.
- R6: The gain code is {unipolar, half-stage, gain[1:0]}. It drives `uni_offset`=code[3], `half_stage`=code[2] and `amp_gain`=code[1:0]. Codes 0–3 mean bipolar 1x/2x/4x/8x, code 4 means bipolar 0.5x, and codes 8–11 mean unipolar 1x/2x/4x/8x. These are the only accepted codes.
- R7: An entry write with a code outside 0–4 and 8–11 leaves that entry unchanged and sets `wr_err`. The flag stays set until cleared.
- R8: `clr_flag` clears `wr_err`. During a run it also returns `cur_idx` to 0, the run continues, and the outputs do not change in that cycle.
- R9: A written length of 0 acts as 1. A length above 16 acts as 16. Values from 1 to 16 set the wrap point directly.
- R10: A length write is taken only in S_IDLE. During a run it has no effect on the wrap point.
- R11: `start` sets `active` and `cur_idx` to 0. `stop` clears `active`. In one cycle, stop takes priority over start and clear, and those take priority over advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_wr | input | 1 | Write one list entry |
| ent_addr | input | 4 | Entry index to write |
| ent_chan | input | 4 | Channel field of the entry |
| ent_gain | input | 4 | Gain code {unipolar, half, gain[1:0]} |
| len_wr | input | 1 | Write list length |
| len_val | input | 5 | Requested length |
| diff_mode | input | 1 | 1 = differential channel mapping |
| start | input | 1 | Begin a run at entry 0 |
| stop | input | 1 | End the run |
| clr_flag | input | 1 | Clear error flag, restart pointer |
| adv | input | 1 | Advance strobe from conversion timing |
| mux_sel | output | 4 | Multiplexer select lines |
| amp_gain | output | 2 | Amplifier gain select |
| half_stage | output | 1 | Selects the 0.5x input stage |
| uni_offset | output | 1 | Selects the unipolar offset |
| active | output | 1 | A run is in progress |
| cur_idx | output | 4 | Index of the next entry to present |
| wr_err | output | 1 | Sticky rejected-write flag |

## Verification
A corrupted pointer or state shows at `cur_idx` right away. On the next advance it also shows at `mux_sel` and the gain lines, because the bench gives each entry a distinct channel and code. A wrong wrap decision is exposed within one pass of the list at the boundary lengths 1, 3 and 16. A storage or validation fault shows up as a refused code reaching the gain lines, or as `wr_err` being out of step with the write the cycle before.

// File: rtl/scan_pkg.sv
package scan_pkg;
    localparam int GAIN_CODE_W = 4;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_STEP = 2'd1,
        S_LAST = 2'd2
    } seq_state_t;

    // accepted codes: bipolar 0..4, unipolar 8..11
    function automatic logic gain_code_ok(input logic [GAIN_CODE_W-1:0] code);
        return (code <= 4'd4) || (code[3:2] == 2'b10);
    endfunction
endpackage

// File: rtl/scan_list.sv
module scan_list
    import scan_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CH_W  = 4,
    parameter int IDX_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_addr,
    input  logic [CH_W-1:0]        wr_chan,
    input  logic [GAIN_CODE_W-1:0] wr_gain,
    input  logic                   err_clr,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [CH_W-1:0]        rd_chan,
    output logic [GAIN_CODE_W-1:0] rd_gain,
    output logic                   wr_err
);
    logic [CH_W-1:0]        chan_q [DEPTH];
    logic [GAIN_CODE_W-1:0] gain_q [DEPTH];
    logic                   code_ok;
    logic                   accept;

    assign code_ok = gain_code_ok(wr_gain);
    assign accept  = wr_en && code_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                chan_q[i] <= '0;
                gain_q[i] <= '0;
            end
        end else if (accept) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_addr == IDX_W'(i)) begin
                    chan_q[i] <= wr_chan;
                    gain_q[i] <= wr_gain;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 wr_err <= 1'b0;
        else if (wr_en && !code_ok) wr_err <= 1'b1;
        else if (err_clr)           wr_err <= 1'b0;
    end

    assign rd_chan = chan_q[rd_idx];
    assign rd_gain = gain_q[rd_idx];
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
    import scan_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             clr,
    input  logic             adv,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_val,
    output logic [IDX_W-1:0] ptr,
    output logic             active,
    output logic             load
);
    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic [LEN_W-1:0] len_q, len_d;
    logic [LEN_W-1:0] nxt;
    seq_state_t       first_st;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v);
        if (v == '0)                     return LEN_W'(1);
        else if (v > LEN_W'(DEPTH))      return LEN_W'(DEPTH);
        else                             return v;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ptr_q   <= '0;
            len_q   <= LEN_W'(1);
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            len_q   <= len_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        len_d   = len_q;
        load    = 1'b0;
        if (state_q == S_IDLE && len_wr) len_d = clamp_len(len_val);
        first_st = (len_d == LEN_W'(1)) ? S_LAST : S_STEP;
        nxt      = LEN_W'(ptr_q) + LEN_W'(1);
        unique case (state_q)
            S_IDLE: begin
                if (start && !stop) begin
                    ptr_d   = '0;
                    state_d = first_st;
                end
            end
            S_STEP, S_LAST: begin
                if (stop) begin
                    state_d = S_IDLE;
                end else if (start || clr) begin
                    ptr_d   = '0;
                    state_d = first_st;
                end else if (adv) begin
                    load = 1'b1;
                    if (state_q == S_LAST) begin
                        ptr_d   = '0;
                        state_d = first_st;
                    end else begin
                        ptr_d   = IDX_W'(nxt);
                        state_d = (nxt == len_q - LEN_W'(1)) ? S_LAST : S_STEP;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ptr    = ptr_q;
        active = (state_q != S_IDLE);
    end
endmodule

// File: rtl/scan_drive.sv
module scan_drive
    import scan_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic                   diff_mode,
    input  logic [CH_W-1:0]        chan,
    input  logic [GAIN_CODE_W-1:0] gain,
    output logic [CH_W-1:0]        mux_sel,
    output logic [1:0]             amp_gain,
    output logic                   half_stage,
    output logic                   uni_offset
);
    logic [CH_W-1:0]        mux_q, mux_d;
    logic [GAIN_CODE_W-1:0] gc_q;

    // differential mode ignores the top select bit
    generate
        if (CH_W > 1) begin : g_mask
            assign mux_d = diff_mode ? {1'b0, chan[CH_W-2:0]} : chan;
        end else begin : g_nomask
            assign mux_d = chan;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_q <= '0;
            gc_q  <= '0;
        end else if (load) begin
            mux_q <= mux_d;
            gc_q  <= gain;
        end
    end

    assign mux_sel    = mux_q;
    assign amp_gain   = gc_q[1:0];
    assign half_stage = gc_q[2];
    assign uni_offset = gc_q[3];
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scan_pkg::*;
#(
    parameter  int DEPTH = 16,
    parameter  int CH_W  = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ent_wr,
    input  logic [IDX_W-1:0]       ent_addr,
    input  logic [CH_W-1:0]        ent_chan,
    input  logic [GAIN_CODE_W-1:0] ent_gain,
    input  logic                   len_wr,
    input  logic [LEN_W-1:0]       len_val,
    input  logic                   diff_mode,
    input  logic                   start,
    input  logic                   stop,
    input  logic                   clr_flag,
    input  logic                   adv,
    output logic [CH_W-1:0]        mux_sel,
    output logic [1:0]             amp_gain,
    output logic                   half_stage,
    output logic                   uni_offset,
    output logic                   active,
    output logic [IDX_W-1:0]       cur_idx,
    output logic                   wr_err
);
    logic [CH_W-1:0]        rd_chan;
    logic [GAIN_CODE_W-1:0] rd_gain;
    logic                   load;

    scan_list #(.DEPTH(DEPTH), .CH_W(CH_W), .IDX_W(IDX_W)) u_list (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ent_wr), .wr_addr(ent_addr), .wr_chan(ent_chan), .wr_gain(ent_gain),
        .err_clr(clr_flag), .rd_idx(cur_idx),
        .rd_chan(rd_chan), .rd_gain(rd_gain), .wr_err(wr_err)
    );

    scan_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start(start), .stop(stop), .clr(clr_flag), .adv(adv),
        .len_wr(len_wr), .len_val(len_val),
        .ptr(cur_idx), .active(active), .load(load)
    );

    scan_drive #(.CH_W(CH_W)) u_drive (
        .clk(clk), .rst_n(rst_n), .load(load), .diff_mode(diff_mode),
        .chan(rd_chan), .gain(rd_gain),
        .mux_sel(mux_sel), .amp_gain(amp_gain),
        .half_stage(half_stage), .uni_offset(uni_offset)
    );
endmodule

// File: rtl/scan_sequencer_chk.sv
module scan_sequencer_chk
    import scan_pkg::*;
#(
    parameter  int DEPTH = 16,
    parameter  int CH_W  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ent_wr,
    input logic [GAIN_CODE_W-1:0] ent_gain,
    input logic                   diff_mode,
    input logic                   start,
    input logic                   stop,
    input logic                   clr_flag,
    input logic                   adv,
    input logic [CH_W-1:0]        mux_sel,
    input logic [1:0]             amp_gain,
    input logic                   half_stage,
    input logic                   uni_offset,
    input logic                   active,
    input logic [IDX_W-1:0]       cur_idx,
    input logic                   wr_err
);
    logic step_ok;
    assign step_ok = active && adv && !stop && !start && !clr_flag;

    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_ok |=> ($stable(mux_sel) && $stable({uni_offset, half_stage, amp_gain})));

    // R5
    diff_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok && diff_mode) |=> !mux_sel[CH_W-1]);

    // R6
    gain_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_code_ok({uni_offset, half_stage, amp_gain}));

    // R7
    bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_wr && !gain_code_ok(ent_gain)) |=> wr_err);

    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flag && !(ent_wr && !gain_code_ok(ent_gain))) |=> !wr_err);

    // R11
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop) |=> (active && cur_idx == '0));

    // R11
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !active);

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_ok |=> (cur_idx == IDX_W'($past(cur_idx) + 1'b1) || cur_idx == '0));
endmodule

bind scan_sequencer scan_sequencer_chk #(.DEPTH(DEPTH), .CH_W(CH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ent_wr(ent_wr), .ent_gain(ent_gain),
    .diff_mode(diff_mode), .start(start), .stop(stop), .clr_flag(clr_flag),
    .adv(adv), .mux_sel(mux_sel), .amp_gain(amp_gain), .half_stage(half_stage),
    .uni_offset(uni_offset), .active(active), .cur_idx(cur_idx), .wr_err(wr_err)
);

// File: tb/sim_scan_sequencer.sv
module sim_scan_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ent_wr = 1'b0;
    logic [3:0] ent_addr = '0;
    logic [3:0] ent_chan = '0;
    logic [3:0] ent_gain = '0;
    logic       len_wr = 1'b0;
    logic [4:0] len_val = '0;
    logic       diff_mode = 1'b0;
    logic       start = 1'b0, stop = 1'b0, clr_flag = 1'b0, adv = 1'b0;
    logic [3:0] mux_sel;
    logic [1:0] amp_gain;
    logic       half_stage, uni_offset, active, wr_err;
    logic [3:0] cur_idx;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    scan_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .ent_wr(ent_wr), .ent_addr(ent_addr),
        .ent_chan(ent_chan), .ent_gain(ent_gain), .len_wr(len_wr), .len_val(len_val),
        .diff_mode(diff_mode), .start(start), .stop(stop), .clr_flag(clr_flag),
        .adv(adv), .mux_sel(mux_sel), .amp_gain(amp_gain), .half_stage(half_stage),
        .uni_offset(uni_offset), .active(active), .cur_idx(cur_idx), .wr_err(wr_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_entry(input int idx, input int ch, input int gc);
        ent_addr = 4'(idx); ent_chan = 4'(ch); ent_gain = 4'(gc); ent_wr = 1'b1;
        @(negedge clk);
        ent_wr = 1'b0;
    endtask

    task automatic wr_len(input int n);
        len_val = 5'(n); len_wr = 1'b1;
        @(negedge clk);
        len_wr = 1'b0;
    endtask

    task automatic do_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic do_stop();
        stop = 1'b1; @(negedge clk); stop = 1'b0;
    endtask

    task automatic do_clr();
        clr_flag = 1'b1; @(negedge clk); clr_flag = 1'b0;
    endtask

    task automatic step_expect(input string tag, input int ch, input int gc, input int idx);
        adv = 1'b1; @(negedge clk); adv = 1'b0;
        chk({tag, " mux"}, 32'(mux_sel), 32'(ch));
        chk({tag, " gain"}, 32'({uni_offset, half_stage, amp_gain}), 32'(gc));
        chk({tag, " idx"}, 32'(cur_idx), 32'(idx));
    endtask

    task automatic t_reset();
        chk("R1 mux", 32'(mux_sel), 0);
        chk("R1 gain", 32'({uni_offset, half_stage, amp_gain}), 0);
        chk("R1 active", 32'(active), 0);
        chk("R1 idx", 32'(cur_idx), 0);
        chk("R1 err", 32'(wr_err), 0);
    endtask

    task automatic t_cycle();
        int chs[3] = '{0, 1, 7};
        int gcs[3] = '{0, 4, 1};
        for (int i = 0; i < 3; i++) wr_entry(i, chs[i], gcs[i]);
        wr_len(3);
        do_start();
        chk("R11 start active", 32'(active), 1);
        chk("R11 start idx", 32'(cur_idx), 0);
        for (int k = 0; k < 8; k++)
            step_expect("R2 R3 cycle", chs[k % 3], gcs[k % 3], (k + 1) % 3);
        do_stop();
        chk("R11 stop", 32'(active), 0);
    endtask

    task automatic t_idle_ignore();
        adv = 1'b1; @(negedge clk); adv = 1'b0;
        chk("R4 idle mux", 32'(mux_sel), 1);
        chk("R4 idle gain", 32'({uni_offset, half_stage, amp_gain}), 4);
        chk("R4 idle idx", 32'(cur_idx), 2);
    endtask

    task automatic t_decode();
        wr_entry(0, 15, 11);
        wr_entry(1, 10, 8);
        wr_len(2);
        do_start();
        step_expect("R6 R5 se", 15, 11, 1);
        chk("R6 uni", 32'(uni_offset), 1);
        chk("R6 amp", 32'(amp_gain), 3);
        step_expect("R5 se", 10, 8, 0);
        diff_mode = 1'b1;
        step_expect("R5 diff", 7, 11, 1);
        step_expect("R5 diff", 2, 8, 0);
        diff_mode = 1'b0;
        do_stop();
        wr_entry(2, 3, 4);
        wr_len(3);
        do_start();
        step_expect("R6 pre", 15, 11, 1);
        step_expect("R6 pre", 10, 8, 2);
        step_expect("R6 half", 3, 4, 0);
        chk("R6 half bit", 32'(half_stage), 1);
        do_stop();
        wr_len(2);
    endtask

    task automatic t_bad_write();
        wr_entry(0, 5, 5);
        chk("R7 err set", 32'(wr_err), 1);
        wr_entry(1, 6, 13);
        chk("R7 err sticky", 32'(wr_err), 1);
        do_start();
        step_expect("R7 entry kept", 15, 11, 1);
        step_expect("R7 entry kept", 10, 8, 0);
        step_expect("R8 pre", 15, 11, 1);
        do_clr();
        chk("R8 err clr", 32'(wr_err), 0);
        chk("R8 idx", 32'(cur_idx), 0);
        chk("R8 active", 32'(active), 1);
        chk("R8 mux hold", 32'(mux_sel), 15);
        step_expect("R8 restart", 15, 11, 1);
        do_stop();
    endtask

    task automatic t_length();
        wr_len(0);
        do_start();
        for (int k = 0; k < 3; k++) step_expect("R9 len0", 15, 11, 0);
        do_stop();
        for (int i = 0; i < 16; i++) wr_entry(i, i, (i % 2 == 1) ? 9 : 2);
        wr_len(20);
        do_start();
        for (int k = 0; k < 17; k++)
            step_expect("R9 len16", k % 16, (k % 2 == 1) ? 9 : 2, (k + 1) % 16);
        wr_len(2);
        step_expect("R10 run len", 1, 9, 2);
        step_expect("R10 run len", 2, 2, 3);
        do_stop();
    endtask

    task automatic t_priority();
        do_start();
        step_expect("R11 p", 0, 2, 1);
        step_expect("R11 p", 1, 9, 2);
        clr_flag = 1'b1; adv = 1'b1; @(negedge clk); clr_flag = 1'b0; adv = 1'b0;
        chk("R11 clr over adv mux", 32'(mux_sel), 1);
        chk("R11 clr over adv idx", 32'(cur_idx), 0);
        step_expect("R11 p", 0, 2, 1);
        stop = 1'b1; adv = 1'b1; @(negedge clk); stop = 1'b0; adv = 1'b0;
        chk("R11 stop over adv active", 32'(active), 0);
        chk("R11 stop over adv idx", 32'(cur_idx), 1);
        chk("R11 stop over adv mux", 32'(mux_sel), 0);
        start = 1'b1; adv = 1'b1; @(negedge clk); start = 1'b0; adv = 1'b0;
        chk("R11 start over adv idx", 32'(cur_idx), 0);
        chk("R11 start over adv active", 32'(active), 1);
        do_stop();
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cycle();
        t_idle_ignore();
        t_decode();
        t_bad_write();
        t_length();
        t_priority();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule